// File: doc/BRIEF.md
# Network Controller Run-Control Unit

This block sequences a network controller between three states: stopped, fetching its initialization block, and running. A host issues one-cycle command writes that carry three write-1-to-act bits: halt, initialize and start. Initialization runs a fixed four-cycle fetch and then latches two mode bits that keep the transmitter or the receiver off. It also raises a one-cycle pulse that sends both descriptor ring pointers back to the first entry of their rings. The unit reports, on separate pins, whether the transmitter and the receiver are live.

Error inputs shut off the side they affect. A side that was shut off stays off until the next full initialization. A three-bit secondary configuration register (byte order, address-latch style, bus control) can only be written while the unit is halted, and every halt clears it to zero. Halting and then starting again without initialization is allowed. That path resumes with the modes already held, but the ring pointers are not reset, so a status pin marks them as unreliable.

All pins are plain control and status levels or pulses. No data stream passes through the block, so it has no valid/ready handshake and applies no back-pressure. A write is taken in any cycle where its enable is high.

Top module: `net_runctl`

## Requirements
- R1: After reset, `stopped`=1 and `txon`, `rxon`, `init_done`, `ring_rst`, `ptr_unsafe` are 0. `cfg_q`=0, and both held disable bits are 1.
- R2: A command write with `cmd_stop`=1 makes, on the next cycle, `stopped`=1, `txon`=`rxon`=`init_done`=0 and `cfg_q`=0. `cmd_init` and `cmd_strt` in that same write are ignored, so `ring_rst` stays 0.
- R3: A command write with `cmd_init`=1 and `cmd_stop`=0 drives `ring_rst` high for exactly the one cycle after the write, and `stopped` goes to 0. `init_done` rises on the fourth clock edge after the write edge.
- R4: On the edge where the fetch ends, `mode_dtx` and `mode_drx` are sampled. From then on `txon`=!`mode_dtx` and `rxon`=!`mode_drx`. Values on these pins during the earlier fetch cycles have no effect.
- R5: `cfg_we` loads `cfg_wdata` into `cfg_q` only while `stopped`=1. Bit 0 is byte swap, bit 1 is address-latch style and bit 2 is bus control. Writes in any other state leave `cfg_q` unchanged.
- R6: While running, a one-cycle `err_mem` turns off both sides. A one-cycle `err_uflo` or `err_tbuf` turns off the transmitter only. The change shows on the next cycle.
- R7: A side turned off by an error stays off through a later halt and start. Only a completed initialization can turn it on again.
- R8: A start command (alone) while halted enters running with the held disable bits. It gives no `ring_rst` pulse and sets `ptr_unsafe`=1, which stays 1 until an initialization completes. Before any initialization the held disables are 1, so a start turns neither side on.
- R9: A start command while fetching or running has no effect. A write carrying both `cmd_init` and `cmd_strt` acts as an initialization.
- R10: An initialization write while running turns both sides off and clears `init_done` on the next cycle, then repeats the full fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_stop | input | 1 | Halt command bit (highest priority) |
| cmd_init | input | 1 | Initialize command bit |
| cmd_strt | input | 1 | Start command bit |
| cfg_we | input | 1 | Secondary configuration write strobe |
| cfg_wdata | input | 3 | Configuration data: [0] byte swap, [1] address-latch style, [2] bus control |
| mode_dtx | input | 1 | Transmitter disable from the init block, sampled at fetch end |
| mode_drx | input | 1 | Receiver disable from the init block, sampled at fetch end |
| err_mem | input | 1 | Memory error pulse (both sides) |
| err_uflo | input | 1 | Transmit underflow pulse |
| err_tbuf | input | 1 | Transmit buffer error pulse |
| stopped | output | 1 | Halt readback: 1 while halted |
| init_done | output | 1 | Initialization completed |
| txon | output | 1 | Transmitter live |
| rxon | output | 1 | Receiver live |
| ring_rst | output | 1 | One-cycle ring pointer reset pulse |
| ptr_unsafe | output | 1 | Ring pointers not guaranteed (restart without initialization) |
| cfg_q | output | 3 | Secondary configuration register |

## Verification
A wrong state register shows up at the ports one cycle after the command that should have moved it. `stopped`, `txon` and `rxon` disagree with the command just issued, or `ring_rst` fires on a start. A fetch counter that is off by one moves the rise of `init_done` away from the fourth edge. It also lets early mode pin values leak into `txon`/`rxon`. A dead flag that is lost only shows up later, when a halt and start bring an error-killed side back on. For that reason the bench runs every mode and error combination through that restart.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    RC_HALT  = 2'd0,
    RC_FETCH = 2'd1,
    RC_RUN   = 2'd2
  } rc_state_e;

  localparam int unsigned RC_CFG_W = 3;
  localparam int unsigned RC_SIDES = 2;
endpackage

// File: rtl/rc_fetch_timer.sv
module rc_fetch_timer #(
  parameter int unsigned CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = busy && (cnt_q == LAST) && !start && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (abort) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (done) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST));
  a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/rc_side.sv
module rc_side (
  input  logic clk,
  input  logic rst_n,
  input  logic force_off,
  input  logic kill,
  input  logic clear_dead,
  input  logic load_on,
  input  logic dis,
  output logic on
);
  logic dead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on     <= 1'b0;
      dead_q <= 1'b0;
    end else begin
      if (clear_dead)  dead_q <= 1'b0;
      else if (kill)   dead_q <= 1'b1;

      if (force_off)    on <= 1'b0;
      else if (kill)    on <= 1'b0;
      else if (load_on) on <= !dis && (clear_dead || !dead_q);
    end
  end

  a_r7_dead_off: assert property (@(posedge clk) disable iff (!rst_n)
    dead_q |-> !on);
  a_r6_kill_off: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !on);
endmodule

// File: rtl/net_runctl.sv
module net_runctl #(
  parameter int unsigned FETCH_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic       cmd_stop,
  input  logic       cmd_init,
  input  logic       cmd_strt,
  input  logic       cfg_we,
  input  logic [2:0] cfg_wdata,
  input  logic       mode_dtx,
  input  logic       mode_drx,
  input  logic       err_mem,
  input  logic       err_uflo,
  input  logic       err_tbuf,
  output logic       stopped,
  output logic       init_done,
  output logic       txon,
  output logic       rxon,
  output logic       ring_rst,
  output logic       ptr_unsafe,
  output logic [2:0] cfg_q
);
  import rc_pkg::*;

  rc_state_e state_q;
  logic do_stop, do_init, do_strt, fetch_done, fetch_busy, running;
  logic [RC_SIDES-1:0] dis_q, kill, side_on, dis_sel;
  logic [RC_CFG_W-1:0] cfg_r;

  assign do_stop = cmd_we && cmd_stop;
  assign do_init = cmd_we && cmd_init && !cmd_stop;
  assign do_strt = cmd_we && cmd_strt && !cmd_stop && !cmd_init && (state_q == RC_HALT);
  assign running = (state_q == RC_RUN);

  rc_fetch_timer #(.CYCLES(FETCH_CYCLES)) u_fetch (
    .clk   (clk),
    .rst_n (rst_n),
    .start (do_init),
    .abort (do_stop),
    .busy  (fetch_busy),
    .done  (fetch_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RC_HALT;
      ring_rst   <= 1'b0;
      init_done  <= 1'b0;
      ptr_unsafe <= 1'b0;
      dis_q      <= '1;
      cfg_r      <= '0;
    end else begin
      ring_rst <= do_init;
      if (do_stop) begin
        state_q   <= RC_HALT;
        init_done <= 1'b0;
        cfg_r     <= '0;
      end else begin
        if (cfg_we && state_q == RC_HALT) cfg_r <= cfg_wdata;
        if (do_init) begin
          state_q   <= RC_FETCH;
          init_done <= 1'b0;
        end else if (fetch_done) begin
          state_q    <= RC_RUN;
          init_done  <= 1'b1;
          ptr_unsafe <= 1'b0;
          dis_q      <= {mode_drx, mode_dtx};
        end else if (do_strt) begin
          state_q    <= RC_RUN;
          ptr_unsafe <= 1'b1;
        end
      end
    end
  end

  // side 0 = transmitter, side 1 = receiver
  assign kill[0] = running && (err_mem || err_uflo || err_tbuf);
  assign kill[1] = running && err_mem;
  assign dis_sel = fetch_done ? {mode_drx, mode_dtx} : dis_q;

  for (genvar g = 0; g < RC_SIDES; g++) begin : g_side
    rc_side u_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .force_off  (do_stop || do_init),
      .kill       (kill[g]),
      .clear_dead (fetch_done),
      .load_on    (fetch_done || do_strt),
      .dis        (dis_sel[g]),
      .on         (side_on[g])
    );
  end

  assign txon    = side_on[0];
  assign rxon    = side_on[1];
  assign stopped = (state_q == RC_HALT);
  assign cfg_q   = cfg_r;

  a_r2_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> (stopped && !txon && !rxon && cfg_q == '0 && !ring_rst));
  a_r3_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
    ring_rst |=> !ring_rst);
  a_r8_strt_no_rst: assert property (@(posedge clk) disable iff (!rst_n)
    do_strt |=> (!ring_rst && ptr_unsafe && !stopped));
  a_r4_on_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    (txon || rxon) |-> running);
  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !do_stop) |=> $stable(cfg_q));
  a_r10_init_offs: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> (!txon && !rxon && !init_done && fetch_busy));
endmodule

// File: tb/net_runctl_tb_top.sv
module net_runctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_we = 0, cmd_stop = 0, cmd_init = 0, cmd_strt = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_wdata = '0;
  logic mode_dtx = 0, mode_drx = 0;
  logic err_mem = 0, err_uflo = 0, err_tbuf = 0;
  logic stopped, init_done, txon, rxon, ring_rst, ptr_unsafe;
  logic [2:0] cfg_q;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  net_runctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(cmd_we), .cmd_stop(cmd_stop), .cmd_init(cmd_init), .cmd_strt(cmd_strt),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mode_dtx(mode_dtx), .mode_drx(mode_drx),
    .err_mem(err_mem), .err_uflo(err_uflo), .err_tbuf(err_tbuf),
    .stopped(stopped), .init_done(init_done), .txon(txon), .rxon(rxon),
    .ring_rst(ring_rst), .ptr_unsafe(ptr_unsafe), .cfg_q(cfg_q)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic s, input logic i, input logic t);
    cmd_we = 1; cmd_stop = s; cmd_init = i; cmd_strt = t;
    @(negedge clk);
    cmd_we = 0; cmd_stop = 0; cmd_init = 0; cmd_strt = 0;
  endtask

  task automatic cfgw(input logic [2:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "stopped", stopped, 1);
    chk("R1", "txon", txon, 0);
    chk("R1", "rxon", rxon, 0);
    chk("R1", "init_done", init_done, 0);
    chk("R1", "ring_rst", ring_rst, 0);
    chk("R1", "ptr_unsafe", ptr_unsafe, 0);
    chk("R1", "cfg_q", cfg_q, 0);

    // R5 config write while halted
    cfgw(3'b101);
    chk("R5", "cfg halted write", cfg_q, 5);

    // R8 start before any init: held disables are 1
    cmd(0, 0, 1);
    chk("R8", "running", stopped, 0);
    chk("R8", "no ring_rst", ring_rst, 0);
    chk("R8", "unsafe", ptr_unsafe, 1);
    chk("R8", "tx off pre-init", txon, 0);
    chk("R8", "rx off pre-init", rxon, 0);
    chk("R5", "cfg kept while running", cfg_q, 5);
    cmd(1, 0, 0);
    chk("R2", "cfg cleared by stop", cfg_q, 0);

    for (int m = 0; m < 4; m++) begin
      for (int e = 0; e < 4; e++) begin
        logic dtx, drx;
        int exp_tx, exp_rx;
        dtx = m[0]; drx = m[1];
        cfgw(3'(m + e));
        chk("R5", "cfg value", cfg_q, (m + e) % 8);
        // R4: opposite mode pins during fetch must be ignored
        mode_dtx = !dtx; mode_drx = !drx;
        cmd(0, 1, (e == 2));
        chk("R3", "ring_rst pulse", ring_rst, 1);
        chk("R3", "left halt", stopped, 0);
        chk("R10", "tx off in fetch", txon, 0);
        chk("R5", "cfg survives init", cfg_q, (m + e) % 8);
        cmd(0, 0, 1); // R9 start during fetch ignored
        chk("R3", "pulse width", ring_rst, 0);
        @(negedge clk);
        mode_dtx = dtx; mode_drx = drx;
        @(negedge clk);
        chk("R3", "init_done early", init_done, 0);
        @(negedge clk);
        mode_dtx = !dtx; mode_drx = !drx;
        chk("R3", "init_done at 4th edge", init_done, 1);
        chk("R4", "txon", txon, !dtx);
        chk("R4", "rxon", rxon, !drx);
        chk("R9", "unsafe after init", ptr_unsafe, 0);
        cfgw(3'b111);
        chk("R5", "cfg locked in run", cfg_q, (m + e) % 8);
        cmd(0, 0, 1);
        chk("R9", "start in run no effect", ptr_unsafe, 0);
        chk("R9", "txon unchanged", txon, !dtx);
        // R6 error pulse
        err_mem = (e == 1); err_uflo = (e == 2); err_tbuf = (e == 3);
        @(negedge clk);
        err_mem = 0; err_uflo = 0; err_tbuf = 0;
        exp_tx = (!dtx && e == 0) ? 1 : 0;
        exp_rx = (!drx && e != 1) ? 1 : 0;
        chk("R6", "txon after err", txon, exp_tx);
        chk("R6", "rxon after err", rxon, exp_rx);
        // R7/R8 halt then start without init
        cmd(1, 0, 0);
        chk("R2", "halted", stopped, 1);
        chk("R2", "tx off", txon, 0);
        cmd(0, 0, 1);
        chk("R8", "restart no pulse", ring_rst, 0);
        chk("R8", "restart unsafe", ptr_unsafe, 1);
        chk("R7", "tx after restart", txon, exp_tx);
        chk("R7", "rx after restart", rxon, exp_rx);
        // R2 stop with init+start in same write
        cmd(1, 1, 1);
        chk("R2", "stop wins", stopped, 1);
        chk("R2", "no pulse on stop", ring_rst, 0);
        chk("R2", "unsafe kept", ptr_unsafe, 1);
      end
    end

    // R10 init while running, R7 error cleared by init
    mode_dtx = 0; mode_drx = 0;
    cmd(0, 1, 0);
    repeat (4) @(negedge clk);
    err_mem = 1; @(negedge clk); err_mem = 0;
    chk("R7", "both dead", txon + rxon, 0);
    cmd(0, 1, 0);
    chk("R10", "init in run clears done", init_done, 0);
    chk("R10", "pulse", ring_rst, 1);
    repeat (4) @(negedge clk);
    chk("R7", "init revives tx", txon, 1);
    chk("R7", "init revives rx", rxon, 1);
    chk("R10", "done again", init_done, 1);
    finish_run();
  end
endmodule